// File: doc/BRIEF.md
# Register Window with Loopback Test Registers and Byte Self-Test Engine

This block is a 32-bit memory-mapped register slave that serves the lowest page of a device's register window. A strobe bus (separate write and read enables, a byte address, 32-bit data) reaches a small set of registers that software uses to prove that the path to the device works. There is a guard range that always answers with a fixed marker, a 32-bit and a 64-bit loopback register that answer with twice the value stored, and a register that raises an interrupt request for any vector written to it. There is also a tiny self-test engine that clears, fills or inverts a run of bytes in a local memory.

The self-test engine takes a start offset and a byte count from two registers. Writing an operation code to the control register starts it. It then changes one byte per clock, wrapping modulo the memory size, holds a busy flag while it works and pulses a done flag as it finishes. The local memory is visible on the same bus as a window of little-endian words, so software can seed the buffer and check the result.

Top module: `regwin_selftest`

## Requirements
- R1: Any byte address in 0x000–0x00F reads 0xDEADBABE; writes there change no register and no memory byte.
- R2: Any address not listed in these requirements (for example 0x014, 0x03C, or an unaligned address such as 0x011) reads 0 and ignores writes.
- R3: Register 0x010 reads as twice the last value written, modulo 2^32 (the carry out of bit 31 is dropped); it reads 0 after reset.
- R4: The 64-bit loopback register has its low word at 0x018 and high word at 0x01C. A write to 0x018 only fills a staging word. A write to 0x01C commits {written word, staging word} as the new 64-bit value. Reads return twice the committed value modulo 2^64: the low half at 0x018, the high half at 0x01C.
- R5: A write to 0x020 raises irq_valid for exactly the one cycle after the write, with irq_vec equal to wdata[7:0]; reading 0x020 returns that vector zero-extended. irq_valid is low in every other cycle.
- R6: The engine start offset is a 64-bit read/write register (low word 0x028, high word 0x02C), and the byte count is a 32-bit read/write register at 0x030.
- R7: A write of exactly 1 (clear to 0x00), 2 (fill with 0x96) or 4 (invert each byte) to 0x034 starts an operation over count bytes. The bytes run from index (start offset mod 64) upward, wrapping modulo 64. Any other value starts nothing and leaves memory unchanged. Reading 0x034 returns the last accepted code (0 after reset).
- R8: An accepted operation raises st_busy in the cycle after the control write and keeps it high for exactly count cycles, one byte per cycle. st_done is high for the single cycle in which st_busy has just fallen. A count of 0 gives st_done in the cycle after the write with no busy cycle.
- R9: Control writes made while st_busy is high are ignored: the running operation, its range and the value read at 0x034 are unaffected.
- R10: The 64-byte memory appears at 0x040–0x07F as little-endian words (byte 4k in bits 7:0 of the word at 0x040+4k). Bus writes to it are ignored while st_busy is high. Memory is all zero after reset.
- R11: A read strobe in one cycle gives rd_valid and rd_data in the next cycle only; rd_valid is low after any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data, little-endian |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector of the interrupt request |
| st_busy | output | 1 | Self-test engine working |
| st_done | output | 1 | One-cycle pulse at end of a self-test operation |

## Verification
The hardest situation to reach from the ports is a bus access that collides with a running self-test operation. Examples are a second control code or a memory-window write arriving while bytes are still being changed, and ranges that wrap past the last memory byte. The stimulus reaches these with a long directed operation into which foreign writes are inserted mid-flight. Random operations also use start offsets well beyond the memory size and counts that cross the wrap point. A byte-level model in the bench predicts every memory word and the exact busy length.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int unsigned OFF_GUARD_END = 'h010;
    localparam int unsigned OFF_T32       = 'h010;
    localparam int unsigned OFF_T64_LO    = 'h018;
    localparam int unsigned OFF_T64_HI    = 'h01C;
    localparam int unsigned OFF_IRQ       = 'h020;
    localparam int unsigned OFF_SADDR_LO  = 'h028;
    localparam int unsigned OFF_SADDR_HI  = 'h02C;
    localparam int unsigned OFF_SIZE      = 'h030;
    localparam int unsigned OFF_CTRL      = 'h034;
    localparam logic [31:0] GUARD_MARK    = 32'hDEADBABE;
    localparam logic [7:0]  FILL_BYTE     = 8'h96;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_CLEAR  = 3'd1,
        OP_FILL   = 3'd2,
        OP_INVERT = 3'd4
    } st_op_e;
endpackage

// File: rtl/regwin_bytemem.sv
module regwin_bytemem #(
    parameter int MEM_BYTES = 64,
    localparam int MEM_AW = $clog2(MEM_BYTES),
    localparam int WORD_AW = MEM_AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [WORD_AW-1:0] bus_widx,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rword,
    input  logic               eng_we,
    input  logic [MEM_AW-1:0]  eng_idx,
    input  logic [7:0]         eng_wbyte,
    output logic [7:0]         eng_rbyte
);
    logic [7:0] mem_q [MEM_BYTES];
    logic [7:0] mem_d [MEM_BYTES];

    always_comb begin
        mem_d = mem_q;
        if (bus_we) begin
            for (int b = 0; b < 4; b++) begin
                mem_d[{bus_widx, 2'(b)}] = bus_wdata[8*b +: 8];
            end
        end
        if (eng_we) begin
            mem_d[eng_idx] = eng_wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign bus_rword = {mem_q[{bus_widx, 2'd3}], mem_q[{bus_widx, 2'd2}],
                        mem_q[{bus_widx, 2'd1}], mem_q[{bus_widx, 2'd0}]};
    assign eng_rbyte = mem_q[eng_idx];
endmodule

// File: rtl/regwin_st_engine.sv
module regwin_st_engine
    import regwin_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    localparam int MEM_AW = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  st_op_e            op,
    input  logic [MEM_AW-1:0] base,
    input  logic [31:0]       count,
    output logic              accepted,
    output logic              busy,
    output logic              done,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_idx,
    output logic [7:0]        mem_wbyte,
    input  logic [7:0]        mem_rbyte
);
    typedef struct packed {
        logic              busy;
        logic              done;
        st_op_e            op;
        logic [MEM_AW-1:0] ptr;
        logic [31:0]       remain;
    } eng_t;

    eng_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accepted = 1'b0;
        mem_we   = 1'b0;
        if (s_q.busy) begin
            mem_we     = 1'b1;
            s_d.ptr    = s_q.ptr + 1'b1;
            s_d.remain = s_q.remain - 32'd1;
            if (s_q.remain == 32'd1) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (start) begin
            accepted   = 1'b1;
            s_d.op     = op;
            s_d.ptr    = base;
            s_d.remain = count;
            if (count == 32'd0) s_d.done = 1'b1;
            else                s_d.busy = 1'b1;
        end
        unique case (s_q.op)
            OP_FILL:   mem_wbyte = FILL_BYTE;
            OP_INVERT: mem_wbyte = ~mem_rbyte;
            default:   mem_wbyte = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, done: 1'b0, op: OP_NONE, ptr: '0, remain: '0};
        else        s_q <= s_d;
    end

    assign mem_idx = s_q.ptr;
    assign busy    = s_q.busy;
    assign done    = s_q.done;
endmodule

// File: rtl/regwin_selftest.sv
module regwin_selftest
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int VEC_W     = 8,
    parameter int MEM_BYTES = 64,
    parameter int MEM_BASE  = 'h040,
    localparam int MEM_AW   = $clog2(MEM_BYTES),
    localparam int WORD_AW  = MEM_AW - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              st_busy,
    output logic              st_done
);
    typedef struct packed {
        logic [31:0]      t32;
        logic [63:0]      t64;
        logic [31:0]      stage;
        logic [VEC_W-1:0] vec;
        logic [63:0]      saddr;
        logic [31:0]      size;
        st_op_e           last_op;
        logic             irq_valid;
        logic             rd_valid;
        logic [31:0]      rd_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] mem_off;
    logic              in_guard, in_mem, ctrl_code_ok, start, accepted;
    logic [31:0]       mem_rword;
    logic [63:0]       t64_dbl;
    logic              eng_we;
    logic [MEM_AW-1:0] eng_idx;
    logic [7:0]        eng_wbyte, eng_rbyte;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    assign mem_off      = addr - ADDR_W'(MEM_BASE);
    assign in_guard     = addr < ADDR_W'(OFF_GUARD_END);
    assign in_mem       = (addr >= ADDR_W'(MEM_BASE)) && (mem_off < ADDR_W'(MEM_BYTES));
    assign ctrl_code_ok = (wdata == 32'd1) || (wdata == 32'd2) || (wdata == 32'd4);
    assign start        = wr_en && hit(addr, OFF_CTRL) && ctrl_code_ok;
    assign t64_dbl      = r_q.t64 << 1;

    always_comb begin
        r_d           = r_q;
        r_d.irq_valid = 1'b0;
        r_d.rd_valid  = rd_en;
        r_d.rd_data   = '0;
        if (wr_en) begin
            if (hit(addr, OFF_T32))      r_d.t32   = wdata;
            if (hit(addr, OFF_T64_LO))   r_d.stage = wdata;
            if (hit(addr, OFF_T64_HI))   r_d.t64   = {wdata, r_q.stage};
            if (hit(addr, OFF_SADDR_LO)) r_d.saddr[31:0]  = wdata;
            if (hit(addr, OFF_SADDR_HI)) r_d.saddr[63:32] = wdata;
            if (hit(addr, OFF_SIZE))     r_d.size  = wdata;
            if (hit(addr, OFF_IRQ)) begin
                r_d.vec       = wdata[VEC_W-1:0];
                r_d.irq_valid = 1'b1;
            end
        end
        if (accepted) r_d.last_op = st_op_e'(wdata[2:0]);
        if (rd_en) begin
            if (in_guard)                     r_d.rd_data = GUARD_MARK;
            else if (in_mem)                  r_d.rd_data = mem_rword;
            else if (hit(addr, OFF_T32))      r_d.rd_data = r_q.t32 << 1;
            else if (hit(addr, OFF_T64_LO))   r_d.rd_data = t64_dbl[31:0];
            else if (hit(addr, OFF_T64_HI))   r_d.rd_data = t64_dbl[63:32];
            else if (hit(addr, OFF_IRQ))      r_d.rd_data = 32'(r_q.vec);
            else if (hit(addr, OFF_SADDR_LO)) r_d.rd_data = r_q.saddr[31:0];
            else if (hit(addr, OFF_SADDR_HI)) r_d.rd_data = r_q.saddr[63:32];
            else if (hit(addr, OFF_SIZE))     r_d.rd_data = r_q.size;
            else if (hit(addr, OFF_CTRL))     r_d.rd_data = 32'(r_q.last_op);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{last_op: OP_NONE, default: '0};
        else        r_q <= r_d;
    end

    regwin_st_engine #(.MEM_BYTES(MEM_BYTES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (st_op_e'(wdata[2:0])),
        .base      (r_q.saddr[MEM_AW-1:0]),
        .count     (r_q.size),
        .accepted  (accepted),
        .busy      (st_busy),
        .done      (st_done),
        .mem_we    (eng_we),
        .mem_idx   (eng_idx),
        .mem_wbyte (eng_wbyte),
        .mem_rbyte (eng_rbyte)
    );

    regwin_bytemem #(.MEM_BYTES(MEM_BYTES)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (wr_en && in_mem && !st_busy),
        .bus_widx  (mem_off[MEM_AW-1:2]),
        .bus_wdata (wdata),
        .bus_rword (mem_rword),
        .eng_we    (eng_we),
        .eng_idx   (eng_idx),
        .eng_wbyte (eng_wbyte),
        .eng_rbyte (eng_rbyte)
    );

    assign rd_valid  = r_q.rd_valid;
    assign rd_data   = r_q.rd_data;
    assign irq_valid = r_q.irq_valid;
    assign irq_vec   = r_q.vec;
endmodule

// File: rtl/regwin_selftest_chk.sv
module regwin_selftest_chk
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              irq_valid,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              st_busy,
    input logic              st_done
);
    assert_guard_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr < ADDR_W'(OFF_GUARD_END)) |=> rd_data == GUARD_MARK);

    assert_hole_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'('h014)) |=> rd_data == 32'd0);

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_IRQ)) |=> (irq_valid && irq_vec == $past(wdata[VEC_W-1:0])));

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(OFF_IRQ)) |=> !irq_valid);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |=> !st_done);

    assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_busy) |-> st_done);

    assert_busy_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_busy |-> !st_done);

    assert_ctrl_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_busy && wr_en && addr == ADDR_W'(OFF_CTRL)) |=> (st_busy || st_done));

    assert_rd_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

bind regwin_selftest regwin_selftest_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .st_busy   (st_busy),
    .st_done   (st_done)
);

// File: tb/sim_regwin_selftest.sv
`timescale 1ns/1ps
module sim_regwin_selftest;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rd_valid, irq_valid, st_busy, st_done;
    logic [31:0] rd_data;
    logic [7:0]  irq_vec;

    int checks = 0, errors = 0;
    logic [7:0]  model [64];
    logic [63:0] t64_model = '0;
    logic [31:0] t32_model = '0;
    logic [31:0] stage_model = '0;
    logic [2:0]  op_model = '0;

    always #5 clk = ~clk;

    regwin_selftest u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .st_busy(st_busy), .st_done(st_done));

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        chk(rd_valid === 1'b1, "R11 rd_valid", 64'(rd_valid), 64'd1);
        d = rd_data;
    endtask

    task automatic expect_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        logic [31:0] d;
        bus_read(a, d);
        chk(d === e, tag, 64'(d), 64'(e));
    endtask

    function automatic logic [31:0] model_word(input int w);
        return {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]};
    endfunction

    function automatic logic [7:0] op_byte(input logic [2:0] op, input logic [7:0] old);
        case (op)
            3'd1: return 8'h00;
            3'd2: return 8'h96;
            default: return ~old;
        endcase
    endfunction

    task automatic check_mem(input string tag);
        for (int w = 0; w < 16; w++) expect_read(12'h040 + 12'(4*w), model_word(w), tag);
    endtask

    task automatic apply_model(input logic [2:0] op, input logic [31:0] a, input int sz);
        for (int i = 0; i < sz; i++) begin
            int idx = (int'(a[5:0]) + i) % 64;
            model[idx] = op_byte(op, model[idx]);
        end
        op_model = op;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input int sz);
        int cnt = 0;
        bus_write(12'h028, a);
        bus_write(12'h02C, 32'h0);
        bus_write(12'h030, 32'(sz));
        bus_write(12'h034, 32'(op));
        while (st_busy === 1'b1) begin
            cnt++;
            chk(st_done === 1'b0, "R8 done low while busy", 64'(st_done), 64'd0);
            @(negedge clk);
        end
        chk(cnt == sz, "R8 busy cycles", 64'(cnt), 64'(sz));
        chk(st_done === 1'b1, "R8 done pulse", 64'(st_done), 64'd1);
        @(negedge clk);
        chk(st_done === 1'b0, "R8 done single", 64'(st_done), 64'd0);
        apply_model(op, a, sz);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, r, h;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(rd_valid === 1'b0 && irq_valid === 1'b0 && st_busy === 1'b0 && st_done === 1'b0,
            "R11 R5 R8 reset outputs", {60'd0, rd_valid, irq_valid, st_busy, st_done}, 64'd0);
        expect_read(12'h010, 32'h0, "R3 reset value");
        expect_read(12'h034, 32'h0, "R7 reset ctrl");
        check_mem("R10 reset memory");

        // R1 guard window
        expect_read(12'h000, 32'hDEADBABE, "R1 guard 0x000");
        expect_read(12'h00F, 32'hDEADBABE, "R1 guard 0x00F");
        bus_write(12'h004, 32'h12345678);
        expect_read(12'h004, 32'hDEADBABE, "R1 guard after write");
        check_mem("R1 guard write no memory effect");

        // R2 holes
        bus_write(12'h014, 32'hCAFEF00D);
        expect_read(12'h014, 32'h0, "R2 hole 0x014");
        expect_read(12'h03C, 32'h0, "R2 hole 0x03C");
        bus_write(12'h011, 32'h5);
        expect_read(12'h011, 32'h0, "R2 unaligned");
        expect_read(12'h010, 32'h0, "R2 unaligned write no effect on t32");

        // R3 overflow corner
        bus_write(12'h010, 32'h80000001);
        expect_read(12'h010, 32'h00000002, "R3 carry dropped");

        // R4 staging and overflow corner
        bus_write(12'h018, 32'h00000001);
        expect_read(12'h018, 32'h0, "R4 lo staged only");
        bus_write(12'h01C, 32'h80000000);
        expect_read(12'h018, 32'h00000002, "R4 lo doubled");
        expect_read(12'h01C, 32'h00000000, "R4 hi carry dropped");
        bus_write(12'h018, 32'h80000000);
        bus_write(12'h01C, 32'h00000001);
        expect_read(12'h01C, 32'h00000003, "R4 carry into hi");

        // R5 interrupt
        bus_write(12'h020, 32'hFFFFFF3C);
        chk(irq_valid === 1'b1 && irq_vec === 8'h3C, "R5 irq pulse", {irq_valid, irq_vec}, {1'b1, 8'h3C});
        @(negedge clk);
        chk(irq_valid === 1'b0, "R5 irq single", 64'(irq_valid), 64'd0);
        expect_read(12'h020, 32'h3C, "R5 vector readback");

        // R6 address and size registers
        bus_write(12'h028, 32'hA5A5_0001);
        bus_write(12'h02C, 32'h0000_BEEF);
        bus_write(12'h030, 32'h0000_0123);
        expect_read(12'h028, 32'hA5A5_0001, "R6 start lo");
        expect_read(12'h02C, 32'h0000_BEEF, "R6 start hi");
        expect_read(12'h030, 32'h0000_0123, "R6 size");

        // R10 memory window seed
        for (int w = 0; w < 16; w++) begin
            r = $urandom;
            bus_write(12'h040 + 12'(4*w), r);
            {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]} = r;
        end
        check_mem("R10 window seed");

        // R7 R8 directed operations: fill with wrap, zero count, invert, clear
        run_op(3'd2, 32'd60, 8);
        check_mem("R7 fill with wrap");
        run_op(3'd4, 32'd3, 0);
        check_mem("R8 zero count");
        run_op(3'd4, 32'd130, 20);
        check_mem("R7 invert");
        run_op(3'd1, 32'd10, 5);
        check_mem("R7 clear");
        expect_read(12'h034, 32'd1, "R7 ctrl readback");

        // R7 invalid code
        bus_write(12'h030, 32'd4);
        bus_write(12'h034, 32'd3);
        chk(st_busy === 1'b0 && st_done === 1'b0, "R7 invalid code no start",
            {62'd0, st_busy, st_done}, 64'd0);
        check_mem("R7 invalid code memory");
        expect_read(12'h034, 32'd1, "R7 invalid code ctrl");

        // R9 R10 collisions while busy
        bus_write(12'h028, 32'd0);
        bus_write(12'h030, 32'd30);
        bus_write(12'h034, 32'd4);
        chk(st_busy === 1'b1, "R8 busy after start", 64'(st_busy), 64'd1);
        bus_write(12'h034, 32'd1);
        bus_write(12'h040, 32'h11223344);
        bus_write(12'h07C, 32'h55667788);
        while (st_busy === 1'b1) @(negedge clk);
        apply_model(3'd4, 32'd0, 30);
        check_mem("R9 R10 writes during busy ignored");
        expect_read(12'h034, 32'd4, "R9 ctrl readback unchanged");

        // random mix
        for (int it = 0; it < 150; it++) begin
            case ($urandom % 6)
                0: begin
                    r = $urandom; t32_model = r;
                    bus_write(12'h010, r);
                    expect_read(12'h010, t32_model << 1, "R3 random");
                end
                1: begin
                    r = $urandom; h = $urandom;
                    bus_write(12'h018, r); stage_model = r;
                    d = 32'(t64_model << 1);
                    expect_read(12'h018, d, "R4 random staged");
                    bus_write(12'h01C, h); t64_model = {h, stage_model};
                    d = 32'((t64_model << 1) >> 32);
                    expect_read(12'h01C, d, "R4 random hi");
                end
                2: begin
                    int w = int'($urandom % 16);
                    r = $urandom;
                    bus_write(12'h040 + 12'(4*w), r);
                    {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]} = r;
                    w = int'($urandom % 16);
                    expect_read(12'h040 + 12'(4*w), model_word(w), "R10 random word");
                end
                3: begin
                    logic [2:0] op;
                    int k = int'($urandom % 3);
                    op = (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : 3'd4;
                    run_op(op, $urandom % 256, int'($urandom % 40));
                    check_mem("R7 random op");
                end
                4: begin
                    r = $urandom;
                    bus_write(12'h020, r);
                    chk(irq_valid === 1'b1 && irq_vec === r[7:0], "R5 random irq",
                        {irq_valid, irq_vec}, {1'b1, r[7:0]});
                end
                default: begin
                    logic [11:0] a = 12'($urandom % 16);
                    bus_write(a, $urandom);
                    expect_read(a, 32'hDEADBABE, "R1 random guard");
                    expect_read(12'h014 + 12'(($urandom % 2) * 40), 32'h0, "R2 random hole");
                end
            endcase
        end

        @(negedge clk);
        chk(rd_valid === 1'b0, "R11 idle", 64'(rd_valid), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule